// File: doc/BRIEF.md
# Software Interrupt Vector Controller

This block sits between the instruction decoder and the CPU fetch logic. It takes decoded strobes for three kinds of software interrupt (a generic request that carries a vector operand, a nonmaskable request and a trap). It also takes an active-low nonmaskable interrupt pin, a set of level-sensitive maskable hardware requests and a return-from-interrupt strobe. From these it produces a one-cycle branch request together with the vector index the CPU should jump to. It also keeps the global interrupt-mask flag.

Each request type has its own mask rule. The nonmaskable request and the generic request set the mask. A trap leaves the mask as it was, so a trap handler can still be preempted by maskable hardware interrupts. When several requests arrive in one cycle, a fixed priority picks one and drops the others. Every output is registered, so a strobe sampled at one rising edge is visible on the outputs after that edge.

Top module: `swint_vector_ctrl`

## Requirements
- R1: During and right after synchronous reset, `branch_o` is 0, `vec_o` is 0 and `mask_o` is 1.
- R2: A generic request (`gen_instr_i`=1) that wins arbitration gives, after the sampling edge, a one-cycle `branch_o`, `vec_o` equal to the sampled `gen_vec_i`, and `mask_o`=1.
- R3: The nonmaskable strobe (`nmi_instr_i`=1) gives, after the sampling edge, `branch_o`=1, `vec_o`=0x24 and `mask_o`=1.
- R4: A high-to-low transition on `nmi_pin_n_i` passes through a two-flop synchronizer and an edge detector. `branch_o` then rises after the third rising edge following the transition, with `vec_o`=0x24 and `mask_o`=1. Holding the pin low afterwards raises no further request.
- R5: A trap strobe that wins arbitration gives `branch_o`=1 and `vec_o`=0x22, and leaves `mask_o` at its previous value, whether that value was 0 or 1.
- R6: Same-cycle requests are served in this order: nonmaskable (pin edge or strobe), then generic, then trap, then hardware. Losing strobes are dropped and do not branch later.
- R7: The hardware request `hw_irq_i[i]` is taken only while `mask_o`=0 and no software request is present. The lowest set index wins, `vec_o` = 0x01 + i, and `mask_o` becomes 1.
- R8: `rti_i` clears `mask_o` unless a mask-setting request is granted in the same cycle. A trap granted together with `rti_i` still branches, and the mask ends at 0.
- R9: `branch_o` is high for exactly one cycle per granted request, and it stays 0 in cycles with no grantable request. `vec_o` holds its last value.
- R10: The mask rule follows the request type, not the vector. A generic request whose operand is 0x22 still sets `mask_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nmi_pin_n_i | input | 1 | Asynchronous active-low nonmaskable interrupt pin |
| nmi_instr_i | input | 1 | Decoded nonmaskable software request strobe |
| gen_instr_i | input | 1 | Decoded generic software interrupt strobe |
| gen_vec_i | input | 6 | Vector operand of the generic request |
| trap_instr_i | input | 1 | Decoded trap strobe |
| hw_irq_i | input | 4 | Maskable hardware interrupt request levels |
| rti_i | input | 1 | Return-from-interrupt strobe |
| branch_o | output | 1 | One-cycle branch request to the CPU |
| vec_o | output | 6 | Vector index of the granted request |
| mask_o | output | 1 | Global interrupt-mask flag (1 = maskable interrupts blocked) |

## Verification
A vector table drives the request types one at a time, starting from both mask states. This separates the trap's hold-the-mask rule from the setting rule of the generic and nonmaskable requests, including a generic request that uses the trap's own vector. Rows that carry several simultaneous strobes and hardware levels confirm each step of the priority order, and show that losers are dropped rather than deferred. Hardware rows with the mask set and with it clear show the gating and the lowest-index choice. Directed pin sequences measure the synchronizer latency exactly, show that a held-low pin raises a single request, and show that a pin edge beats a generic strobe in the cycle where the edge is recognised.

// File: rtl/swint_pkg.sv
package swint_pkg;
  // Grant vector bit positions, highest priority at the top.
  localparam int GNT_W    = 4;
  localparam int GNT_NMI  = 3;
  localparam int GNT_GEN  = 2;
  localparam int GNT_TRAP = 1;
  localparam int GNT_HW   = 0;

  typedef logic [GNT_W-1:0] gnt_t;
endpackage

// File: rtl/swint_nmi_sync.sv
// Synchronizes the active-low NMI pin and emits a one-cycle pulse on its
// falling edge.
module swint_nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= pin_n_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[STAGES-2:0], pin_n_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

  // A held-low pin yields only one pulse.
  assert_single_edge_R4: assert property (@(posedge clk) disable iff (rst)
    fall_o |=> !fall_o);
endmodule

// File: rtl/swint_arbiter.sv
// Fixed-priority selection of one request per cycle and its vector.
module swint_arbiter
  import swint_pkg::*;
#(
  parameter int              VEC_W    = 6,
  parameter int              NUM_HW   = 4,
  parameter logic [VEC_W-1:0] NMI_VEC  = 6'h24,
  parameter logic [VEC_W-1:0] TRAP_VEC = 6'h22,
  parameter logic [VEC_W-1:0] HW_BASE  = 6'h01
) (
  input  logic              nmi_req_i,
  input  logic              gen_req_i,
  input  logic [VEC_W-1:0]  gen_vec_i,
  input  logic              trap_req_i,
  input  logic [NUM_HW-1:0] hw_req_i,
  input  logic              mask_i,
  output gnt_t              gnt_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              set_mask_o
);
  logic             hw_any;
  logic [VEC_W-1:0] hw_vec;

  // Lowest index wins: scan from the top so the last hit is the lowest.
  always_comb begin
    hw_any = 1'b0;
    hw_vec = '0;
    for (int i = NUM_HW - 1; i >= 0; i--) begin
      if (hw_req_i[i]) begin
        hw_any = 1'b1;
        hw_vec = HW_BASE + VEC_W'(i);
      end
    end
  end

  always_comb begin
    gnt_o = '0;
    vec_o = '0;
    if (nmi_req_i) begin
      gnt_o[GNT_NMI] = 1'b1;
      vec_o          = NMI_VEC;
    end else if (gen_req_i) begin
      gnt_o[GNT_GEN] = 1'b1;
      vec_o          = gen_vec_i;
    end else if (trap_req_i) begin
      gnt_o[GNT_TRAP] = 1'b1;
      vec_o           = TRAP_VEC;
    end else if (hw_any && !mask_i) begin
      gnt_o[GNT_HW] = 1'b1;
      vec_o         = hw_vec;
    end
  end

  // Trap is the only grant that leaves the mask alone.
  assign set_mask_o = gnt_o[GNT_NMI] | gnt_o[GNT_GEN] | gnt_o[GNT_HW];
endmodule

// File: rtl/swint_mask_reg.sv
// Global interrupt-mask flag.
module swint_mask_reg (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic mask_o
);
  always_ff @(posedge clk) begin
    if (rst)        mask_o <= 1'b1;
    else if (set_i) mask_o <= 1'b1;
    else if (clr_i) mask_o <= 1'b0;
  end

  assert_rti_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !mask_o);
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    set_i |=> mask_o);
endmodule

// File: rtl/swint_vector_ctrl.sv
module swint_vector_ctrl
  import swint_pkg::*;
#(
  parameter int               VEC_W       = 6,
  parameter int               NUM_HW      = 4,
  parameter int               SYNC_STAGES = 2,
  parameter logic [VEC_W-1:0] NMI_VEC     = 6'h24,
  parameter logic [VEC_W-1:0] TRAP_VEC    = 6'h22,
  parameter logic [VEC_W-1:0] HW_BASE     = 6'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_pin_n_i,
  input  logic              nmi_instr_i,
  input  logic              gen_instr_i,
  input  logic [VEC_W-1:0]  gen_vec_i,
  input  logic              trap_instr_i,
  input  logic [NUM_HW-1:0] hw_irq_i,
  input  logic              rti_i,
  output logic              branch_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              mask_o
);
  logic             nmi_fall;
  logic             nmi_req;
  gnt_t             gnt;
  logic [VEC_W-1:0] sel_vec;
  logic             set_mask;
  logic             sw_any;

  swint_nmi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .pin_n_i (nmi_pin_n_i),
    .fall_o  (nmi_fall)
  );

  assign nmi_req = nmi_fall | nmi_instr_i;

  swint_arbiter #(
    .VEC_W    (VEC_W),
    .NUM_HW   (NUM_HW),
    .NMI_VEC  (NMI_VEC),
    .TRAP_VEC (TRAP_VEC),
    .HW_BASE  (HW_BASE)
  ) u_arb (
    .nmi_req_i  (nmi_req),
    .gen_req_i  (gen_instr_i),
    .gen_vec_i  (gen_vec_i),
    .trap_req_i (trap_instr_i),
    .hw_req_i   (hw_irq_i),
    .mask_i     (mask_o),
    .gnt_o      (gnt),
    .vec_o      (sel_vec),
    .set_mask_o (set_mask)
  );

  swint_mask_reg u_mask (
    .clk    (clk),
    .rst    (rst),
    .set_i  (set_mask),
    .clr_i  (rti_i),
    .mask_o (mask_o)
  );

  // Registered branch pulse and vector (vector holds between grants).
  always_ff @(posedge clk) begin
    if (rst) begin
      branch_o <= 1'b0;
      vec_o    <= '0;
    end else begin
      branch_o <= |gnt;
      if (|gnt) vec_o <= sel_vec;
    end
  end

  assign sw_any = nmi_req | gen_instr_i | trap_instr_i;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!branch_o && vec_o == '0 && mask_o));
  assert_generic_R2: assert property (@(posedge clk) disable iff (rst)
    (gen_instr_i && !nmi_req) |=>
      (branch_o && vec_o == $past(gen_vec_i) && mask_o));
  assert_nmi_instr_R3: assert property (@(posedge clk) disable iff (rst)
    nmi_instr_i |=> (branch_o && vec_o == NMI_VEC && mask_o));
  assert_nmi_pin_R4: assert property (@(posedge clk) disable iff (rst)
    nmi_fall |=> (branch_o && vec_o == NMI_VEC && mask_o));
  assert_trap_keeps_mask_R5: assert property (@(posedge clk) disable iff (rst)
    (trap_instr_i && !nmi_req && !gen_instr_i && !rti_i) |=>
      (branch_o && vec_o == TRAP_VEC && mask_o == $past(mask_o)));
  assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));
  assert_hw_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (mask_o && !sw_any) |=> !branch_o);
  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!sw_any && hw_irq_i == '0) |=> !branch_o);
endmodule

// File: tb/sim_swint_vector_ctrl.sv
module sim_swint_vector_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       nmi_pin_n;
  logic       nmi_instr;
  logic       gen_instr;
  logic [5:0] gen_vec;
  logic       trap_instr;
  logic [3:0] hw_irq;
  logic       rti;
  logic       branch;
  logic [5:0] vec;
  logic       mask;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  swint_vector_ctrl u0 (
    .clk(clk), .rst(rst), .nmi_pin_n_i(nmi_pin_n), .nmi_instr_i(nmi_instr),
    .gen_instr_i(gen_instr), .gen_vec_i(gen_vec), .trap_instr_i(trap_instr),
    .hw_irq_i(hw_irq), .rti_i(rti), .branch_o(branch), .vec_o(vec),
    .mask_o(mask)
  );

  // Row: nmi, gen, gvec[6], trap, hw[4], rti | exp branch, exp vec[6], exp mask
  localparam int NROWS = 18;
  localparam logic [21:0] TBL [NROWS] = '{
    {1'b0,1'b0,6'h00,1'b0,4'h0,1'b0, 1'b0,6'h00,1'b1},
    {1'b0,1'b1,6'h15,1'b0,4'h0,1'b0, 1'b1,6'h15,1'b1},
    {1'b0,1'b0,6'h00,1'b0,4'h0,1'b1, 1'b0,6'h15,1'b0},
    {1'b0,1'b0,6'h00,1'b1,4'h0,1'b0, 1'b1,6'h22,1'b0},
    {1'b0,1'b1,6'h30,1'b0,4'h0,1'b0, 1'b1,6'h30,1'b1},
    {1'b0,1'b0,6'h00,1'b1,4'h0,1'b0, 1'b1,6'h22,1'b1},
    {1'b0,1'b0,6'h00,1'b0,4'h1,1'b0, 1'b0,6'h22,1'b1},
    {1'b0,1'b0,6'h00,1'b0,4'h0,1'b1, 1'b0,6'h22,1'b0},
    {1'b0,1'b0,6'h00,1'b0,4'h6,1'b0, 1'b1,6'h02,1'b1},
    {1'b0,1'b0,6'h00,1'b0,4'h6,1'b1, 1'b0,6'h02,1'b0},
    {1'b1,1'b1,6'h11,1'b1,4'h6,1'b0, 1'b1,6'h24,1'b1},
    {1'b0,1'b0,6'h00,1'b0,4'h0,1'b1, 1'b0,6'h24,1'b0},
    {1'b0,1'b1,6'h22,1'b1,4'h8,1'b0, 1'b1,6'h22,1'b1},
    {1'b0,1'b0,6'h00,1'b1,4'h0,1'b1, 1'b1,6'h22,1'b0},
    {1'b0,1'b0,6'h00,1'b1,4'h4,1'b0, 1'b1,6'h22,1'b0},
    {1'b0,1'b0,6'h00,1'b0,4'h4,1'b0, 1'b1,6'h03,1'b1},
    {1'b1,1'b0,6'h00,1'b0,4'h0,1'b0, 1'b1,6'h24,1'b1},
    {1'b0,1'b0,6'h00,1'b0,4'h0,1'b0, 1'b0,6'h24,1'b1}
  };
  string tags [NROWS] = '{"R9","R2","R8","R5","R2","R5","R7","R8","R7",
                          "R7","R6","R8","R10","R8","R6","R7","R3","R9"};

  task automatic check(input string tag, input logic eb,
                       input logic [5:0] ev, input logic em);
    n_cmp++;
    if (branch !== eb || vec !== ev || mask !== em) begin
      n_bad++;
      $display("FAIL %s: branch/vec/mask got %b/%h/%b expected %b/%h/%b",
               tag, branch, vec, mask, eb, ev, em);
    end
  endtask

  task automatic drive(input logic n, input logic g, input logic [5:0] gv,
                       input logic t, input logic [3:0] h, input logic r);
    nmi_instr = n; gen_instr = g; gen_vec = gv;
    trap_instr = t; hw_irq = h; rti = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 6'h00, 1'b0, 4'h0, 1'b0);
  endtask

  initial begin
    rst = 1'b1; nmi_pin_n = 1'b1;
    nmi_instr = 0; gen_instr = 0; gen_vec = 0; trap_instr = 0;
    hw_irq = 0; rti = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 in reset", 1'b0, 6'h00, 1'b1);
    rst = 1'b0;

    for (int i = 0; i < NROWS; i++) begin
      drive(TBL[i][21], TBL[i][20], TBL[i][19:14], TBL[i][13],
            TBL[i][12:9], TBL[i][8]);
      check($sformatf("%s row %0d", tags[i], i),
            TBL[i][7], TBL[i][6:1], TBL[i][0]);
    end

    // R4: pin edge latency and single request while held low
    drive(1'b0, 1'b0, 6'h00, 1'b0, 4'h0, 1'b1);
    check("R8 rti before pin", 1'b0, 6'h24, 1'b0);
    nmi_pin_n = 1'b0;
    idle(); check("R4 edge+1", 1'b0, 6'h24, 1'b0);
    idle(); check("R4 edge+2", 1'b0, 6'h24, 1'b0);
    idle(); check("R4 edge+3", 1'b1, 6'h24, 1'b1);
    for (int k = 0; k < 4; k++) begin
      idle(); check("R4 held low", 1'b0, 6'h24, 1'b1);
    end
    nmi_pin_n = 1'b1;
    repeat (3) idle();
    drive(1'b0, 1'b0, 6'h00, 1'b0, 4'h0, 1'b1);
    check("R8 rti", 1'b0, 6'h24, 1'b0);

    // R6: recognised pin edge beats a generic strobe in the same cycle
    nmi_pin_n = 1'b0;
    idle(); idle();
    check("R4 no early branch", 1'b0, 6'h24, 1'b0);
    drive(1'b0, 1'b1, 6'h11, 1'b0, 4'h0, 1'b0);
    check("R6 pin over generic", 1'b1, 6'h24, 1'b1);
    idle(); check("R6 generic dropped", 1'b0, 6'h24, 1'b1);
    nmi_pin_n = 1'b1;
    repeat (3) idle();

    // R1: reset after activity
    rst = 1'b1;
    drive(1'b0, 1'b1, 6'h2a, 1'b0, 4'h0, 1'b0);
    check("R1 reset mid-run", 1'b0, 6'h00, 1'b1);
    rst = 1'b0;
    idle(); check("R1 after reset", 1'b0, 6'h00, 1'b1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule